// File: doc/BRIEF.md
# Masked-Write Random Bit Collector

This block is a memory-mapped random-number peripheral on a 32-bit register bus. Software programs a sample period and a control word that holds an enable flag, an oscillator-speed code and an output-length code. It then sets a start bit. While a collection runs, the block takes one bit from its entropy source at the end of each sample period and places it into an accumulator. When the requested number of bits has been gathered, the accumulator is copied to a bank of output words and the start bit drops.

Writes to the control register are bit-masked. The upper half of the written word says which of the low control bits the write may change, so software can start a collection without reading back the configuration first. Because the start bit stays high until the data is valid, it also serves as the busy flag that software polls.

The physical entropy source is replaced by a free-running linear-feedback shift register. This keeps the block synthesizable and its output predictable.

Top module: `trng_front`

## Requirements
- R1: After reset, the control register (0x400), the sample-count register (0x404) and every output word (0x410 to 0x42C) read 0. Any unmapped address, such as 0x408, also reads 0.
- R2: In a write to 0x400, control bit n (n = 1..5) takes the written bit n only when written bit n+16 is 1. Otherwise it keeps its value. Control bits 15:6 and 31:16 always read 0.
- R3: Control bits 3:2 (speed code) and 5:4 (length code) read back as written. A length code c selects a collection of 64*(c+1) bits.
- R4: A write to 0x400 with bit 16 and bit 0 set starts a collection, provided ENABLE (bit 1, taking this same write into account) is 1. Bit 0 then reads 1 until the collection completes, exactly N*P clock edges after the write edge, and reads 0 from then on.
- R5: A start request made while ENABLE is 0 is ignored. Bit 0 stays 0 and the output words do not change.
- R6: Register 0x404 holds the sample period P, measured in clock cycles. A value of 0 behaves as 1. Bit k of a collection is taken from the source at the edge (k+1)*P cycles after the start write edge.
- R7: The source is a 16-bit register s, seeded with 0xACE1 by reset, that advances on every clock to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The sampled bit is s[0].
- R8: Collected bit k appears at bit k%32 of the word at 0x410 + 4*(k/32). After a collection completes, the words above its length read 0.
- R9: Output words keep their contents until a collection completes, including when a collection is aborted.
- R10: Writing 0xFFFF0000 to 0x400 clears every control field and aborts a running collection. Bit 0 reads 0 afterwards, and the sample-count register is unchanged.
- R11: While a collection runs, writing start as 0 or writing start again has no effect: the collection keeps its timing and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
Register reads are combinational, so the effect of a write is visible in the low phase that follows its edge. The completion of a collection is due exactly N*P edges after the start write edge. The bench counts edges from that write and samples the start bit once one edge before that point, expecting 1, and once just after it, expecting 0. The expected output bits come from a bench model of the source register stepped from its seed, with bit k taken at cycle index c0+(k+1)*P, where c0 is the bench's cycle count before the write edge. The bench sweeps every length code against several sample periods, including zero.

// File: rtl/trng_pkg.sv
package trng_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int SRC_W  = 16;

    localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h400;
    localparam logic [ADDR_W-1:0] SCNT_OFS = 12'h404;
    localparam logic [ADDR_W-1:0] DOUT_OFS = 12'h410;

    localparam logic [SRC_W-1:0] SRC_SEED = 16'hACE1;

    typedef enum logic [1:0] {
        LEN_64  = 2'd0,
        LEN_128 = 2'd1,
        LEN_192 = 2'd2,
        LEN_256 = 2'd3
    } len_e;

    typedef struct packed {
        len_e       len;
        logic [1:0] speed;
        logic       en;
    } ctrl_t;

    function automatic logic [SRC_W-1:0] src_step(input logic [SRC_W-1:0] s);
        return {s[SRC_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int unsigned len_bits(input len_e c);
        return (int'(c) + 1) * 64;
    endfunction

endpackage

// File: rtl/trng_src.sv
module trng_src
    import trng_pkg::*;
#(
    parameter logic [SRC_W-1:0] SEED = SRC_SEED
) (
    input  logic clk,
    input  logic rst,
    output logic bit_o
);
    logic [SRC_W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= src_step(state);
    end

    assign bit_o = state[0];

    // R7: a correct feedback polynomial never reaches the all-zero lock-up state
    p_src_live_r7: assert property (@(posedge clk) disable iff (rst) state != '0);
endmodule

// File: rtl/trng_regs.sv
module trng_regs
    import trng_pkg::*;
#(
    parameter int SCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output ctrl_t             ctrl,
    output logic [SCNT_W-1:0] scnt,
    output logic              go,
    output logic              stop
);
    localparam int MASK_SH = DATA_W / 2;

    logic              ctrl_wr, scnt_wr;
    logic [MASK_SH-1:0] mask;
    ctrl_t             nxt;
    logic [1:0]        ln, sp;
    logic              en;

    assign ctrl_wr = we && (addr == CTRL_OFS);
    assign scnt_wr = we && (addr == SCNT_OFS);
    assign mask    = wdata[DATA_W-1:MASK_SH];

    always_comb begin
        ln = ctrl.len;
        sp = ctrl.speed;
        en = ctrl.en;
        if (mask[1]) en = wdata[1];
        for (int i = 0; i < 2; i++) begin
            if (mask[2+i]) sp[i] = wdata[2+i];
            if (mask[4+i]) ln[i] = wdata[4+i];
        end
        nxt = '{len: len_e'(ln), speed: sp, en: en};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{len: LEN_64, speed: 2'b00, en: 1'b0};
            scnt <= '0;
        end else begin
            if (ctrl_wr) ctrl <= nxt;
            if (scnt_wr) scnt <= wdata[SCNT_W-1:0];
        end
    end

    assign go   = ctrl_wr && mask[0] && wdata[0] && nxt.en && !busy;
    assign stop = ctrl_wr && mask[1] && !wdata[1];

    // R2: a control write with an all-zero mask leaves the control fields untouched
    p_nomask_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && mask == '0) |=> $stable(ctrl));
endmodule

// File: rtl/trng_collect.sv
module trng_collect
    import trng_pkg::*;
#(
    parameter int MAX_BITS = 256,
    parameter int SCNT_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                stop,
    input  logic [SCNT_W-1:0]   period,
    input  len_e                len_sel,
    input  logic                src_bit,
    output logic                busy_o,
    output logic [MAX_BITS-1:0] bits_o
);
    localparam int IDX_W = $clog2(MAX_BITS + 1);
    localparam int BIT_W = $clog2(MAX_BITS);

    logic                busy;
    logic [SCNT_W-1:0]   cnt, per_q;
    logic [IDX_W-1:0]    idx, nbits_q;
    logic [MAX_BITS-1:0] acc, acc_nxt, out_q;
    logic                tick, last, done;

    assign tick = busy && (cnt == per_q - 1'b1);
    assign last = (idx == nbits_q - 1'b1);
    assign done = tick && last && !stop;

    always_comb begin
        acc_nxt = acc;
        if (tick) acc_nxt[idx[BIT_W-1:0]] = src_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            per_q   <= '0;
            idx     <= '0;
            nbits_q <= '0;
            acc     <= '0;
            out_q   <= '0;
        end else if (go) begin
            busy    <= 1'b1;
            cnt     <= '0;
            idx     <= '0;
            acc     <= '0;
            nbits_q <= IDX_W'(len_bits(len_sel));
            per_q   <= (period == '0) ? SCNT_W'(1) : period;
        end else if (busy) begin
            if (stop) begin
                busy <= 1'b0;
            end else if (tick) begin
                cnt <= '0;
                acc <= acc_nxt;
                idx <= idx + 1'b1;
                if (last) begin
                    busy  <= 1'b0;
                    out_q <= acc_nxt;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign busy_o = busy;
    assign bits_o = out_q;

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst) done |=> !busy);
    p_out_hold_r9:  assert property (@(posedge clk) disable iff (rst) !done |=> $stable(out_q));
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst) busy |-> (cnt < per_q));
    p_idx_bound_r8: assert property (@(posedge clk) disable iff (rst) busy |-> (idx < nbits_q));
endmodule

// File: rtl/trng_front.sv
module trng_front
    import trng_pkg::*;
#(
    parameter int               MAX_BITS = 256,
    parameter int               SCNT_W   = 16,
    parameter logic [SRC_W-1:0] SEED     = SRC_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int NWORDS = MAX_BITS / DATA_W;

    ctrl_t               ctrl;
    logic [SCNT_W-1:0]   scnt;
    logic                go, stop, busy, src_bit;
    logic [MAX_BITS-1:0] bits;
    logic [ADDR_W-1:0]   woff;
    logic [ADDR_W-3:0]   widx;

    trng_src #(.SEED(SEED)) u_src (
        .clk   (clk),
        .rst   (rst),
        .bit_o (src_bit)
    );

    trng_regs #(.SCNT_W(SCNT_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .busy  (busy),
        .ctrl  (ctrl),
        .scnt  (scnt),
        .go    (go),
        .stop  (stop)
    );

    trng_collect #(.MAX_BITS(MAX_BITS), .SCNT_W(SCNT_W)) u_coll (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .stop    (stop),
        .period  (scnt),
        .len_sel (ctrl.len),
        .src_bit (src_bit),
        .busy_o  (busy),
        .bits_o  (bits)
    );

    assign woff = bus_addr - DOUT_OFS;
    assign widx = woff[ADDR_W-1:2];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata = {26'b0, ctrl.len, ctrl.speed, ctrl.en, busy};
        end else if (bus_addr == SCNT_OFS) begin
            bus_rdata = {{(DATA_W-SCNT_W){1'b0}}, scnt};
        end else if (bus_addr >= DOUT_OFS && woff[1:0] == 2'b00
                     && int'(widx) < NWORDS) begin
            bus_rdata = bits[int'(widx)*DATA_W +: DATA_W];
        end
    end

    // R10: a collection can only be running while the unit is enabled
    p_busy_en_r10: assert property (@(posedge clk) disable iff (rst) busy |-> ctrl.en);
    // R5: a start request on a disabled unit that leaves ENABLE unmasked does not start
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_OFS && bus_wdata[16] && bus_wdata[0]
         && !bus_wdata[17] && !ctrl.en && !busy) |=> !busy);
    // R4: a collection only begins on a bus write
    p_start_src_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_we));
endmodule

// File: tb/trng_front_tb.sv
`timescale 1ns/1ps
module trng_front_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int unsigned cyc;
    int unsigned c0;
    int          checks = 0;
    int          fails = 0;
    logic [255:0] expv, prevv;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    trng_front u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    function automatic logic [15:0] adv(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        c0 = cyc;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic predict(input int n, input int p);
        logic [15:0] s;
        int k;
        int unsigned lst;
        s = 16'hACE1;
        k = 0;
        expv = '0;
        lst = c0 + n * p;
        for (int unsigned i = 0; i <= lst; i++) begin
            if (k < n && i == c0 + (k + 1) * p) begin
                expv[k] = s[0];
                k++;
            end
            s = adv(s);
        end
    endtask

    task automatic check_words(input string req, input logic [255:0] v);
        logic [31:0] d;
        for (int w = 0; w < 8; w++) begin
            rd(12'h410 + 12'(w * 4), d);
            chk(req, d, v[w*32 +: 32]);
        end
    endtask

    task automatic run(input int lenc, input int per, input bit poke);
        int n, p, wait_n;
        logic [31:0] d;
        n = 64 * (lenc + 1);
        p = (per == 0) ? 1 : per;
        wr(12'h404, 32'(per));
        wr(12'h400, 32'h0032_0002 | 32'(lenc << 4));
        rd(12'h400, d);
        chk("R3 length code readback", d, 32'h2 | 32'(lenc << 4));
        wr(12'h400, 32'h0001_0001);
        predict(n, p);
        wait_n = n * p - 1;
        if (poke) begin
            // R11: clear-start and repeat-start writes during the run
            wr(12'h400, 32'h0001_0000);
            wr(12'h400, 32'h0001_0001);
            wait_n -= 4;
        end
        repeat (wait_n) @(negedge clk);
        rd(12'h400, d);
        chk(poke ? "R11 start still high one edge early" : "R4 start still high one edge early",
            32'(d[0]), 32'd1);
        @(negedge clk);
        rd(12'h400, d);
        chk(poke ? "R11 start low at N*P" : "R4 start low at N*P", 32'(d[0]), 32'd0);
        check_words(poke ? "R11 data unchanged by pokes" : "R6 R7 R8 collected words", expv);
        prevv = expv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(12'h400, d); chk("R1 control", d, 32'h0);
        rd(12'h404, d); chk("R1 sample count", d, 32'h0);
        rd(12'h408, d); chk("R1 unmapped", d, 32'h0);
        check_words("R1 output words", '0);

        // R2: masked control writes
        wr(12'h400, 32'h0000_003E);
        rd(12'h400, d); chk("R2 unmasked write ignored", d, 32'h0);
        wr(12'h400, 32'h000C_000C);
        rd(12'h400, d); chk("R3 speed readback", d, 32'h0000_000C);
        wr(12'h400, 32'h0004_0000);
        rd(12'h400, d); chk("R2 single bit cleared", d, 32'h0000_0008);
        wr(12'h400, 32'hFFFF_FFC0);
        rd(12'h400, d); chk("R2 upper control bits read 0", d, 32'h0);
        wr(12'h400, 32'h0030_0020);
        rd(12'h400, d); chk("R3 length field only", d, 32'h0000_0020);

        // R5: start on a disabled unit
        wr(12'h400, 32'h0001_0001);
        rd(12'h400, d); chk("R5 start stays 0", d, 32'h0000_0020);
        repeat (20) @(negedge clk);
        check_words("R5 outputs unchanged", '0);

        // sweep of every length against several periods
        for (int lc = 0; lc < 4; lc++) begin
            for (int pi = 0; pi < 4; pi++) begin
                run(lc, pi, 1'b0);
            end
        end
        run(0, 2, 1'b1);
        run(1, 5, 1'b0);

        // R10 and R9: abort with full-mask zero write
        wr(12'h404, 32'd4);
        wr(12'h400, 32'h0032_0032);
        wr(12'h400, 32'h0001_0001);
        repeat (50) @(negedge clk);
        wr(12'h400, 32'hFFFF_0000);
        rd(12'h400, d); chk("R10 control cleared", d, 32'h0);
        rd(12'h404, d); chk("R10 sample count kept", d, 32'd4);
        check_words("R9 outputs held after abort", prevv);
        repeat (300) @(negedge clk);
        check_words("R9 outputs still held", prevv);
        rd(12'h400, d); chk("R10 no restart", d, 32'h0);

        // R5 again after abort
        wr(12'h400, 32'h0001_0001);
        rd(12'h400, d); chk("R5 start ignored after abort", d, 32'h0);
        repeat (40) @(negedge clk);
        check_words("R5 outputs unchanged after ignored start", prevv);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule